// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short command against a serial flash device. Software describes the whole command in a single packed control word: an 8-bit opcode, an optional address of one to four bytes, an optional count of idle (dummy) clocks, and then up to eight bytes sent to the device or up to eight bytes received from it. Software first writes the control word with the execute bit clear, then writes it again with execute set. It polls the in-progress bit until it reads zero.

Bytes to send are taken from two 32-bit staging registers in little-endian order. Received bytes are returned the same way in two separate 32-bit result registers. The block does not toggle serial pins itself. It issues one request per byte, or one request per dummy run, to a byte-level shifter through a request/acknowledge link. It holds that shifter's select line for the whole command.

Register selector values: 0 control, 1 address, 2 send-data low, 3 send-data high, 4 receive-data low, 5 receive-data high. Selectors 6 and 7 read as zero. Registers 4 and 5 cannot be written.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset every readable register returns 0, and `link_req` and `link_sel` are low.
- R2: The control word fields are as follows:
  - bit 0: execute.
  - bit 1: in progress (read-only).
  - bits 11:7: dummy clock count.
  - bits 14:12: send byte count minus one.
  - bit 15: send enable.
  - bits 17:16: address byte count minus one.
  - bit 19: address enable.
  - bits 22:20: receive byte count minus one.
  - bit 23: receive enable.
  - bits 31:24: opcode.

  A control write with bit 0 set, made while idle, starts a command. Bit 1 reads 1 from the next cycle until completion. Bit 0 always reads 0. Undefined bits (6:2, 18) read 0, so writing 0xFFFFFFFE reads back 0xFFFBFF80.
- R3: The phases run in this fixed order, and disabled phases are skipped:
  1. The opcode, as a send request (kind 0).
  2. If address enable is set, the address bytes from register 1, most significant of the selected bytes first.
  3. If the dummy count is non-zero, one dummy request (kind 2) carrying the count on `link_clks`.
  4. The data phase.
- R4: The send phase moves count+1 bytes. Byte k comes from bits 8k+7:8k of {register 3, register 2}.
- R5: The receive phase issues count+1 receive requests (kind 1). At completion, byte k of the received data lands in bits 8k+7:8k of {register 5, register 4}. Bytes beyond the count read 0.
- R6: Registers 4 and 5 keep their previous values during a command. They also keep them after a command without a receive phase.
- R7: While a command is in progress, all register writes are ignored, including a new execute.
- R8: `link_sel` is high exactly while a command is in progress.
- R9: When both send enable and receive enable are set, only the send phase runs.
- R10: A request holds `link_kind`, `link_txd` and `link_clks` stable until it is acknowledged. Kind 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| link_req | output | 1 | Shifter request pending |
| link_kind | output | 2 | 0 send byte, 1 receive byte, 2 dummy clocks |
| link_txd | output | 8 | Byte to send |
| link_clks | output | 5 | Dummy clock count |
| link_ack | input | 1 | Shifter completion pulse |
| link_rxd | input | 8 | Received byte, valid with `link_ack` |
| link_sel | output | 1 | Device select, held for the whole command |

## Verification
The assertions assume that `link_ack` is a single-cycle pulse. They also assume it is raised only while `link_req` is high, so a phase never advances on a stray acknowledge. The bench's shifter model holds to this. It only answers a request it has observed, waits a varying latency, pulses the acknowledge for one cycle, and lowers it before looking for the next request. Register writes come only from the bench's write task, one per strobe.

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [SW-1:0] reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          link_req,
  output logic [1:0]    link_kind,
  output logic [7:0]    link_txd,
  output logic [4:0]    link_clks,
  input  logic          link_ack,
  input  logic [7:0]    link_rxd,
  output logic          link_sel
);
  localparam logic [31:0] FIELD_MASK = 32'hFFFB_FF80;
  localparam int DBITS = 2 * AW;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_WR, S_RD} state_t;

  state_t           state;
  logic [31:0]      ctrl_q;
  logic [AW-1:0]    addr_q, wlo_q, whi_q, rlo_q, rhi_q;
  logic [DBITS-1:0] rbuf, rbuf_in, wbuf;
  logic [2:0]       cnt;
  logic [5:0]       idx;
  logic             busy;

  wire [7:0] f_opc   = ctrl_q[31:24];
  wire       f_rden  = ctrl_q[23];
  wire [2:0] f_rdn   = ctrl_q[22:20];
  wire       f_aden  = ctrl_q[19];
  wire [1:0] f_adn   = ctrl_q[17:16];
  wire       f_wren  = ctrl_q[15];
  wire [2:0] f_wrn   = ctrl_q[14:12];
  wire [4:0] f_dum   = ctrl_q[11:7];

  state_t nx_dummy, nx_addr, nx_opc;
  assign nx_dummy = f_wren ? S_WR : (f_rden ? S_RD : S_IDLE);
  assign nx_addr  = (f_dum != 5'd0) ? S_DUMMY : nx_dummy;
  assign nx_opc   = f_aden ? S_ADDR : nx_addr;

  assign busy      = (state != S_IDLE);
  assign link_sel  = busy;
  assign link_req  = busy;
  assign idx       = {cnt, 3'b000};
  assign wbuf      = {whi_q, wlo_q};
  assign rbuf_in   = rbuf | (DBITS'(link_rxd) << idx);
  assign link_clks = f_dum;

  always_comb begin
    link_kind = 2'd0;
    link_txd  = 8'd0;
    case (state)
      S_OPC:   link_txd  = f_opc;
      S_ADDR:  link_txd  = addr_q[idx +: 8];
      S_DUMMY: link_kind = 2'd2;
      S_WR:    link_txd  = wbuf[idx +: 8];
      S_RD:    link_kind = 2'd1;
      default: ;
    endcase
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = ctrl_q | {30'd0, busy, 1'b0};
      3'd1:    reg_rdata = addr_q;
      3'd2:    reg_rdata = wlo_q;
      3'd3:    reg_rdata = whi_q;
      3'd4:    reg_rdata = rlo_q;
      3'd5:    reg_rdata = rhi_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ctrl_q <= '0;
      addr_q <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      rbuf   <= '0;
      cnt    <= '0;
    end else if (state == S_IDLE) begin
      if (reg_wr) begin
        case (reg_sel)
          3'd0: begin
            ctrl_q <= reg_wdata & FIELD_MASK;
            if (reg_wdata[0]) begin
              state <= S_OPC;
              rbuf  <= '0;
              cnt   <= '0;
            end
          end
          3'd1: addr_q <= reg_wdata;
          3'd2: wlo_q  <= reg_wdata;
          3'd3: whi_q  <= reg_wdata;
          default: ;
        endcase
      end
    end else if (link_ack) begin
      case (state)
        S_OPC: begin
          state <= nx_opc;
          cnt   <= (nx_opc == S_ADDR) ? {1'b0, f_adn} : 3'd0;
        end
        S_ADDR: begin
          if (cnt == 3'd0) state <= nx_addr;
          else cnt <= cnt - 3'd1;
        end
        S_DUMMY: begin
          state <= nx_dummy;
          cnt   <= 3'd0;
        end
        S_WR: begin
          if (cnt == f_wrn) state <= S_IDLE;
          else cnt <= cnt + 3'd1;
        end
        S_RD: begin
          rbuf <= rbuf_in;
          if (cnt == f_rdn) begin
            state <= S_IDLE;
            {rhi_q, rlo_q} <= rbuf_in;
          end else begin
            cnt <= cnt + 3'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic        reg_go,
  input logic        link_req,
  input logic [1:0]  link_kind,
  input logic [7:0]  link_txd,
  input logic [4:0]  link_clks,
  input logic        link_ack,
  input logic        link_sel,
  input logic [31:0] ctrl_q,
  input logic [31:0] addr_q,
  input logic [31:0] rlo_q,
  input logic [31:0] rhi_q
);
  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel == 3'd0 && reg_go));

  // R7
  locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(ctrl_q) && $stable(addr_q)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_req && link_ack && link_kind == 2'd1) |=> ($stable(rlo_q) && $stable(rhi_q)));

  // R8
  sel_covers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> link_sel);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !link_ack) |=> (link_req && $stable(link_kind) && $stable(link_txd) && $stable(link_clks)));

  // R10
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> (link_kind != 2'd3));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_go(reg_wdata[0]), .link_req(link_req), .link_kind(link_kind),
  .link_txd(link_txd), .link_clks(link_clks), .link_ack(link_ack),
  .link_sel(link_sel), .ctrl_q(ctrl_q), .addr_q(addr_q),
  .rlo_q(rlo_q), .rhi_q(rhi_q)
);

// File: tb/flash_cmd_engine_test.sv
`timescale 1ns/1ps
module flash_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_req, link_sel;
  logic [1:0]  link_kind;
  logic [7:0]  link_txd;
  logic [4:0]  link_clks;
  logic        link_ack = 1'b0;
  logic [7:0]  link_rxd = '0;

  always #10 clk = ~clk;

  flash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_req(link_req),
    .link_kind(link_kind), .link_txd(link_txd), .link_clks(link_clks),
    .link_ack(link_ack), .link_rxd(link_rxd), .link_sel(link_sel)
  );

  int checks = 0;
  int fails = 0;

  // order: ctrl, addr, send-low, send-high
  localparam logic [127:0] VEC [0:5] = '{
    {32'h9FA0_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0600_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h020A_F000, 32'h0012_3456, 32'h4433_2211, 32'h8877_6655},
    {32'h0BFB_0400, 32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0000},
    {32'h42B8_9000, 32'h0000_00A7, 32'hCAFE_BABE, 32'h0000_0000},
    {32'h0580_0F80, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  logic [1:0] lk [0:31];
  logic [7:0] lt [0:31];
  logic [4:0] lc [0:31];
  int ln = 0;
  logic [1:0] ek [0:31];
  logic [7:0] et [0:31];
  logic [4:0] ec [0:31];
  int en = 0;
  logic [63:0] exp_r = '0;

  function automatic logic [7:0] rxval(input int n);
    return 8'h5A ^ 8'(n * 37);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (link_req && rst_n) begin
        if (ln < 32) begin
          lk[ln] = link_kind; lt[ln] = link_txd; lc[ln] = link_clks;
        end
        link_rxd = rxval(ln);
        repeat (1 + (ln % 3)) @(negedge clk);
        ln++;
        link_ack = 1'b1;
        @(negedge clk);
        link_ack = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      read_reg(3'd0, v);
      if (!v[1]) break;
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] t, input logic [4:0] c);
    ek[en] = k; et[en] = t; ec[en] = c; en++;
  endtask

  task automatic build_expect(input logic [31:0] c, input logic [31:0] a,
                              input logic [31:0] wl, input logic [31:0] wh);
    logic [63:0] w;
    w = {wh, wl};
    en = 0;
    push(2'd0, c[31:24], 5'd0);
    if (c[19])
      for (int i = int'(c[17:16]); i >= 0; i--) push(2'd0, a[i*8 +: 8], 5'd0);
    if (c[11:7] != 5'd0) push(2'd2, 8'd0, c[11:7]);
    if (c[15]) begin
      for (int k = 0; k <= int'(c[14:12]); k++) push(2'd0, w[k*8 +: 8], 5'd0);
    end else if (c[23]) begin
      exp_r = '0;
      for (int k = 0; k <= int'(c[22:20]); k++) begin
        exp_r[k*8 +: 8] = rxval(en);
        push(2'd1, 8'd0, 5'd0);
      end
    end
  endtask

  task automatic compare_log(input logic [31:0] c);
    logic [31:0] lo, hi;
    check("R3 request count", 64'(ln), 64'(en));
    for (int i = 0; i < en && i < ln; i++) begin
      check(ek[i] == 2'd1 ? "R5 kind" : "R3 kind", 64'(lk[i]), 64'(ek[i]));
      if (ek[i] == 2'd0)
        check((c[15] && i >= en - int'(c[14:12]) - 1) ? "R4 send byte" : "R3 send byte",
              64'(lt[i]), 64'(et[i]));
      if (ek[i] == 2'd2) check("R3 dummy clocks", 64'(lc[i]), 64'(ec[i]));
    end
    read_reg(3'd4, lo);
    read_reg(3'd5, hi);
    check(c[15] ? "R9 result regs" : "R5 R6 result regs", {hi, lo}, exp_r);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1
    for (int s = 0; s < 8; s++) begin
      read_reg(3'(s), v);
      check("R1 register after reset", 64'(v), 64'd0);
    end
    check("R1 link_req/link_sel after reset", {62'd0, link_req, link_sel}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 readback masking without execute
    write_reg(3'd0, 32'hFFFF_FFFE);
    read_reg(3'd0, v);
    check("R2 control readback", 64'(v), 64'h0000_0000_FFFB_FF80);
    check("R2 no start without execute", 64'(ln), 64'd0);
    check("R8 select low while idle", 64'(link_sel), 64'd0);
    write_reg(3'd0, 32'h0);

    foreach (VEC[n]) begin
      logic [31:0] c, a, wl, wh;
      {c, a, wl, wh} = VEC[n];
      write_reg(3'd1, a);
      write_reg(3'd2, wl);
      write_reg(3'd3, wh);
      write_reg(3'd0, c);
      build_expect(c, a, wl, wh);
      ln = 0;
      write_reg(3'd0, c | 32'd1);
      read_reg(3'd0, v);
      check("R2 in-progress set", 64'(v[1:0]), 64'd2);
      wait_idle();
      compare_log(c);
    end

    // R7, R6, R8 directed: writes during a long command
    begin
      logic [31:0] c, a, wl, wh, lo, hi;
      logic [63:0] prev;
      {c, a, wl, wh} = VEC[3];
      prev = exp_r;
      write_reg(3'd1, a);
      write_reg(3'd0, c);
      build_expect(c, a, wl, wh);
      ln = 0;
      write_reg(3'd0, c | 32'd1);
      check("R8 select high while busy", 64'(link_sel), 64'd1);
      read_reg(3'd4, lo);
      read_reg(3'd5, hi);
      check("R6 results held mid-command", {hi, lo}, prev);
      write_reg(3'd0, 32'h0100_0001);
      write_reg(3'd1, 32'h1111_1111);
      wait_idle();
      read_reg(3'd0, v);
      check("R7 control unchanged", 64'(v), 64'(c));
      read_reg(3'd1, v);
      check("R7 address unchanged", 64'(v), 64'(a));
      compare_log(c);
      repeat (10) @(negedge clk);
      check("R7 no second command", 64'(ln), 64'(en));
      check("R8 select low after completion", 64'(link_sel), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule